// File: doc/BRIEF.md
# Edge-Sensing Handshake Parallel Port

This block is one side of a general-purpose parallel port. It has a data output register, a direction register and an 8-bit control register. It also watches two handshake input lines, C1 and C2. A host reaches the registers through a one-bit register select with read and write strobes. One control bit decides whether the data address reaches the output register or the direction register. Each pin whose direction bit is 1 drives the stored output value. Each pin whose direction bit is 0 is read back from the pin.

Both handshake lines pass through a two-flop synchronizer before edge detection. The active edge of each line can be programmed. When that edge occurs, a sticky flag in the control register is set. The interrupt request is raised while a set flag has its enable bit set. Reading the data register clears both flags. C2 is watched only while its direction bit marks it as an input.

Top module: `hs_port`

## Requirements
- R1: After reset the control, output and direction registers read as zero, so every pin is an input (`pin_oe` = 0) and `irq` is low.
- R2: With `sel`=0, control bit 2 routes the access. When bit 2 is 1 the access reaches the output register; when bit 2 is 0 it reaches the direction register. Direction bit n = 1 makes pin n an output (`pin_oe[n]`=1).
- R3: A data read (`sel`=0, bit 2 = 1) returns (`pin_in` AND NOT direction) OR (output register AND direction). `pin_out` equals the output register AND direction.
- R4: Control bit 1 selects the C1 active edge (0 = falling, 1 = rising). The selected edge sets control bit 7 three clock edges after the `c1_in` change. The other edge leaves bit 7 unchanged.
- R5: While control bit 5 is 0, control bit 4 selects the C2 active edge (0 = falling, 1 = rising), and that edge sets control bit 6. While bit 5 is 1, no C2 edge sets bit 6.
- R6: `irq` is high exactly while (bit 7 AND bit 0) OR (bit 6 AND bit 3 AND NOT bit 5).
- R7: Control bits 7 and 6 are read-only. A write with `sel`=1 updates bits 5..0 only.
- R8: A data read (`sel`=0 with bit 2 = 1) clears bits 7 and 6 at that clock edge. Reading the control register or the direction register leaves the flags unchanged.
- R9: No edge is reported until the synchronizer and the previous-state reference hold real samples taken after reset. A level held on C1 through reset never raises a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Register select: 0 = data/direction, 1 = control |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effect: flag clear on data read) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational from `sel` and state) |
| pin_in | input | 8 | Port pin levels |
| pin_out | output | 8 | Port pin drive values |
| pin_oe | output | 8 | Port pin output enables |
| c1_in | input | 1 | Handshake line 1 |
| c2_in | input | 1 | Handshake line 2 |
| irq | output | 1 | Interrupt request |

## Verification
The results of a register write show up at the ports one clock edge after the strobe. `rdata` is combinational, so read values are taken shortly after the select is set, within the same cycle. A change on a handshake line reaches its flag on the third rising edge after the change, and `irq` follows in that same cycle. The bench therefore waits three falling edges before it reads the control register or samples `irq`. Inputs are driven and outputs sampled only on falling edges. The flag clear caused by a data read is checked on the cycle after the strobe.

// File: rtl/hs_port.sv
module hs_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [7:0]   wdata,
  output logic [7:0]   rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  input  logic         c1_in,
  input  logic         c2_in,
  output logic         irq
);

  logic [W-1:0] out_q, dir_q;
  logic [7:0]   ctrl;
  logic         c1_s1, c1_s2, c1_p;
  logic         c2_s1, c2_s2, c2_p;
  logic [1:0]   warm;

  wire data_sel = ctrl[2];
  wire c2_is_in = ~ctrl[5];
  wire armed    = (warm == 2'd3);
  wire c1_hit   = armed & (c1_s2 != c1_p) & (c1_s2 == ctrl[1]);
  wire c2_hit   = armed & c2_is_in & (c2_s2 != c2_p) & (c2_s2 == ctrl[4]);
  wire rd_clr   = rd_en & ~sel & data_sel;
  wire port_wr  = wr_en & ~sel;
  wire ctrl_wr  = wr_en & sel;

  assign pin_out = out_q & dir_q;
  assign pin_oe  = dir_q;
  assign irq     = (ctrl[7] & ctrl[0]) | (ctrl[6] & ctrl[3] & c2_is_in);

  always_comb begin
    rdata = 8'h00;
    if (sel)           rdata = ctrl;
    else if (data_sel) rdata[W-1:0] = (pin_in & ~dir_q) | (out_q & dir_q);
    else               rdata[W-1:0] = dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {c1_s1, c1_s2, c1_p} <= '0;
      {c2_s1, c2_s2, c2_p} <= '0;
      warm <= '0;
    end else begin
      c1_s1 <= c1_in;  c1_s2 <= c1_s1;  c1_p <= c1_s2;
      c2_s1 <= c2_in;  c2_s2 <= c2_s1;  c2_p <= c2_s2;
      if (!armed) warm <= warm + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else if (port_wr) begin
      if (data_sel) out_q <= wdata[W-1:0];
      else          dir_q <= wdata[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else begin
      if (ctrl_wr) ctrl[5:0] <= wdata[5:0];
      ctrl[7] <= c1_hit | (ctrl[7] & ~rd_clr);
      ctrl[6] <= c2_hit | (ctrl[6] & ~rd_clr);
    end
  end

  AST_OUT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0); // R3
  AST_FLAGS_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !c1_hit && !c2_hit) |=> ctrl[7:6] == $past(ctrl[7:6])); // R7
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !c1_hit && !c2_hit) |=> ctrl[7:6] == 2'b00); // R8
  AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !ctrl[3]) |-> !irq); // R6
  AST_C2_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[5] && !ctrl[6]) |=> !ctrl[6]); // R5
  AST_WARMUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed) |=> !$rose(ctrl[7]) && !$rose(ctrl[6])); // R9

endmodule

// File: tb/tb_hs_port.sv
module tb_hs_port;
  logic clk = 0, rst_n = 0;
  logic sel = 0, wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata, pin_in = 0, pin_out, pin_oe;
  logic c1_in = 0, c2_in = 0, irq;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  hs_port dut (.clk, .rst_n, .sel, .wr_en, .rd_en, .wdata, .rdata,
               .pin_in, .pin_out, .pin_oe, .c1_in, .c2_in, .irq);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic s, logic [7:0] d);
    @(negedge clk); sel = s; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic s, output logic [7:0] d, input logic strobe);
    @(negedge clk); sel = s; rd_en = strobe; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wait3();
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset(logic c1lvl);
    rst_n = 0; c1_in = c1lvl; c2_in = 0; pin_in = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    #1;
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rd(1, v, 0); chk("R1 ctrl", v, 8'h00);
    rd(0, v, 0); chk("R1 dir", v, 8'h00);
  endtask

  task automatic t_access();
    logic [7:0] v;
    wr(0, 8'hF0);
    #1 chk("R2 dir write to oe", pin_oe, 8'hF0);
    wr(1, 8'h04);
    wr(0, 8'hA5);
    #1 chk("R2 data write kept dir", pin_oe, 8'hF0);
    chk("R3 pin_out", pin_out, 8'hA0);
    pin_in = 8'h3C;
    rd(0, v, 1); chk("R3 data read mix", v, 8'hAC);
    wr(1, 8'h00);
    rd(0, v, 0); chk("R2 dir read back", v, 8'hF0);
  endtask

  task automatic t_c1();
    logic [7:0] v;
    wr(1, 8'h07);
    @(negedge clk); c1_in = 1; wait3();
    chk("R6 irq on c1", {7'b0, irq}, 8'h01);
    rd(1, v, 1); chk("R4 rising sets bit7 / R8 ctrl read keeps", v, 8'h87);
    wr(1, 8'h06);
    rd(1, v, 0); chk("R7 write keeps flag", v, 8'h86);
    chk("R6 irq off with enable clear", {7'b0, irq}, 8'h00);
    wr(1, 8'h00);
    rd(0, v, 1); rd(1, v, 0); chk("R8 dir read keeps flag", v, 8'h80);
    wr(1, 8'h07);
    rd(0, v, 1); rd(1, v, 0); chk("R8 data read clears", v, 8'h07);
    chk("R6 irq low after clear", {7'b0, irq}, 8'h00);
    @(negedge clk); c1_in = 0; wait3();
    rd(1, v, 0); chk("R4 falling ignored when rising", v, 8'h07);
    wr(1, 8'h04);
    @(negedge clk); c1_in = 1; wait3();
    rd(1, v, 0); chk("R4 rising ignored when falling", v, 8'h04);
    @(negedge clk); c1_in = 0; wait3();
    rd(1, v, 0); chk("R4 falling sets bit7", v, 8'h84);
    chk("R6 no irq without enable", {7'b0, irq}, 8'h00);
    wr(1, 8'hC4);
    rd(0, v, 1); rd(1, v, 0); chk("R7 write cannot set flags", v, 8'h04);
  endtask

  task automatic t_c2();
    logic [7:0] v;
    wr(1, 8'h1C);
    @(negedge clk); c2_in = 1; wait3();
    chk("R6 irq on c2", {7'b0, irq}, 8'h01);
    rd(1, v, 0); chk("R5 c2 rising sets bit6", v, 8'h5C);
    rd(0, v, 1); rd(1, v, 0); chk("R8 clears bit6", v, 8'h1C);
    wr(1, 8'h3C);
    @(negedge clk); c2_in = 0; wait3();
    @(negedge clk); c2_in = 1; wait3();
    rd(1, v, 0); chk("R5 c2 output mode no flag", v, 8'h3C);
    chk("R6 irq low c2 output", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_warm();
    logic [7:0] v;
    do_reset(1'b1);
    wr(1, 8'h06);
    repeat (8) @(negedge clk);
    rd(1, v, 0); chk("R9 held level no flag", v, 8'h06);
  endtask

  initial begin
    fork
      begin
        do_reset(1'b0);
        t_reset();
        t_access();
        t_c1();
        t_c2();
        t_warm();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule